// File: doc/BRIEF.md
# Byte-Wide Self-Timed EEPROM Control Core

This block is a clocked, synthesizable model of the control section of a byte-wide parallel EEPROM. The host sees an asynchronous SRAM-style port: an address, a data bus split into input, output and output enable, and active-low chip select, read strobe and write strobe. Reads work like a static RAM. A byte write, however, is self-timed. The block latches the address and data, then holds a busy state. During that state it first erases the target byte and then programs it. The busy state is shown on an open-drain style ready/busy output.

While busy, the host can poll the device by reading. Bit 7 returns the complement of the byte being written, so the host sees the true value only once the cycle has completed. A separate high-voltage flag on the read strobe selects a whole-array clear, which sets every byte to 0xFF.

All four control inputs pass through two-flop synchronizers, and the address and data pass through a matching two-stage pipeline. Every edge decision is therefore made on signals aligned to the system clock. The array is a register file of 2^ADDR_W bytes. Setting ADDR_W to 13 gives the full 8192-byte organisation.

Top module: `eep_ctrl`

## Requirements
- R1: The array stores 2^ADDR_W bytes. After a completed write to any address, including address 0 and the top address, a read of that address returns the written byte.
- R2: `data_oe` is 1 only when `ce_n` and `oe_n` are both low, seen through a two-cycle synchronizer. With `ce_n` high, `data_oe` is 0 whatever the value of `oe_n`. Whenever `data_oe` is 0, `data_o` is 0x00.
- R3: A byte write is requested once `ce_n` and `we_n` are both low while `oe_n` is high and `oe_hv` is low. The address and data are captured when the first of `ce_n`/`we_n` rises. Bus changes made after that capture do not alter the stored byte.
- R4: After capture, the write cycle lasts WRITE_CYC clocks. The byte is first erased to 0xFF and then programmed, after which the device is ready again.
- R5: `rdy_pull_low` is 1 from the write request until the write cycle ends, and 0 whenever the device is idle.
- R6: While busy, a read returns {~latched_data[7], 7'b0} at any address. After completion, the same read returns the true byte.
- R7: A chip clear runs when `ce_n` is low and `oe_hv` has been high for at least CLR_SETUP clocks before `we_n` falls. It starts when `we_n` rises again. It sets every byte to 0xFF and holds busy for CLEAR_CYC clocks. A poll read during the clear returns 0x00.
- R8: A clear pulse whose `oe_hv` setup is shorter than CLR_SETUP clocks is ignored. Busy stays 0 and the stored data is unchanged.
- R9: Write or clear requests that arrive while busy are ignored. They neither change memory nor start a new cycle afterwards.
- R10: After reset, `rdy_pull_low` is 0, `data_oe` is 0 and `data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Byte address from host |
| data_i | input | 8 | Write data from host |
| data_o | output | 8 | Read data or polling status |
| data_oe | output | 1 | Data bus drive enable |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_hv | input | 1 | High-voltage level on the read strobe (clear mode) |
| rdy_pull_low | output | 1 | Open-drain ready/busy: 1 pulls the line low (busy) |

## Verification
The assertions assume the following about the host bus:
- address and data stay stable for at least two clocks after the capturing rising strobe, because they travel through the same two-stage pipeline as the controls;
- `oe_hv` is never dropped while `we_n` and `ce_n` are both still low, since that would turn a clear pulse into a byte write;
- write cycles are never shorter than two clocks.

The stimulus respects all three. It holds address and data for three clocks after each write strobe rises. It raises `we_n` before releasing `oe_hv`. It keeps every strobe low for at least four clocks, so each edge passes cleanly through the synchronizers.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int          BYTE_W = 8;
    localparam logic [7:0]  ERASED = 8'hFF;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WARM,
        S_ERASE,
        S_PROG,
        S_CARM,
        S_CLEAR
    } seq_state_e;

    // Control strobes after synchronization, all active high.
    typedef struct packed {
        logic ce;
        logic oe;
        logic we;
        logic hv;
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] poll_word(input logic [BYTE_W-1:0] d);
        return {~d[BYTE_W-1], {(BYTE_W-1){1'b0}}};
    endfunction
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;
    logic [W-1:0] s2;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                s1[i] <= 1'b0;
                s2[i] <= 1'b0;
            end else begin
                s1[i] <= d[i];
                s2[i] <= s1[i];
            end
        end
    end

    assign q = s2;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/eep_seq.sv
module eep_seq
    import eep_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int WRITE_CYC = 375000,
    parameter int CLEAR_CYC = 1250000,
    parameter int CLR_SETUP = 125
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctl,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic [7:0]        held_data
);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int ERASE_CYC = WRITE_CYC / 2;
    localparam int PROG_CYC  = WRITE_CYC - ERASE_CYC;
    localparam int MAXC      = (CLEAR_CYC > WRITE_CYC) ? CLEAR_CYC : WRITE_CYC;
    localparam int CW        = $clog2(MAXC + 1);
    localparam int HW        = $clog2(CLR_SETUP + 1);

    seq_state_e        state;
    logic [CW-1:0]     cnt;
    logic [ADDR_W-1:0] lat_addr;
    logic [7:0]        lat_data;
    logic              we_d;
    logic [HW-1:0]     hv_cnt;

    logic wr_cond, we_fall, we_rise, clr_ok;

    assign wr_cond = ctl.ce & ctl.we & ~ctl.oe & ~ctl.hv;
    assign we_fall = ctl.we & ~we_d;
    assign we_rise = ~ctl.we & we_d;
    assign clr_ok  = ctl.ce & ctl.hv & we_fall & (hv_cnt >= HW'(CLR_SETUP));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            cnt      <= '0;
            lat_addr <= '0;
            lat_data <= '0;
            we_d     <= 1'b0;
            hv_cnt   <= '0;
        end else begin
            we_d <= ctl.we;
            if (!ctl.hv) begin
                hv_cnt <= '0;
            end else if (hv_cnt < HW'(CLR_SETUP)) begin
                hv_cnt <= hv_cnt + 1'b1;
            end
            case (state)
                S_IDLE: begin
                    if (wr_cond) begin
                        state <= S_WARM;
                    end else if (clr_ok) begin
                        state <= S_CARM;
                    end
                end
                S_WARM: begin
                    if (!wr_cond) begin
                        lat_addr <= bus_addr;
                        lat_data <= bus_data;
                        cnt      <= '0;
                        state    <= S_ERASE;
                    end
                end
                S_ERASE: begin
                    if (cnt == CW'(ERASE_CYC - 1)) begin
                        cnt   <= '0;
                        state <= S_PROG;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_PROG: begin
                    if (cnt == CW'(PROG_CYC - 1)) begin
                        cnt   <= '0;
                        state <= S_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_CARM: begin
                    if (we_rise) begin
                        lat_data <= ERASED;
                        cnt      <= '0;
                        state    <= S_CLEAR;
                    end
                end
                S_CLEAR: begin
                    if (cnt == CW'(CLEAR_CYC - 1)) begin
                        cnt   <= '0;
                        state <= S_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = lat_addr;
        mem_wdata = ERASED;
        case (state)
            S_ERASE: mem_we = (cnt == '0);
            S_PROG: begin
                mem_we    = (cnt == CW'(PROG_CYC - 1));
                mem_wdata = lat_data;
            end
            S_CLEAR: begin
                mem_we   = (cnt < CW'(DEPTH));
                mem_addr = cnt[ADDR_W-1:0];
            end
            default: ;
        endcase
    end

    assign busy      = (state != S_IDLE);
    assign held_data = lat_data;

    // R5: a write request seen while idle raises busy on the next cycle
    a_r5_busy_on_request: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && wr_cond) |=> busy);

    // R9: latched target stays frozen for the whole timed cycle
    a_r9_latch_frozen: assert property (@(posedge clk) disable iff (rst)
        ((state == S_ERASE || state == S_PROG) &&
         ($past(state) == S_ERASE || $past(state) == S_PROG))
        |-> ($stable(lat_addr) && $stable(lat_data)));

    // R4: ready returns only from the end of a timed phase
    a_r4_ready_after_timer: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(state) == S_PROG || $past(state) == S_CLEAR));

    // R4: erase phase counter stays inside its window
    a_r4_erase_window: assert property (@(posedge clk) disable iff (rst)
        (state == S_ERASE) |-> (cnt < CW'(ERASE_CYC)));
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int WRITE_CYC = 375000,
    parameter int CLEAR_CYC = 1250000,
    parameter int CLR_SETUP = 125
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    output logic [7:0]        data_o,
    output logic              data_oe,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              oe_hv,
    output logic              rdy_pull_low
);
    localparam int BUS_W = ADDR_W + BYTE_W;

    ctrl_t             ctl;
    logic [3:0]        ctl_raw;
    logic [3:0]        ctl_s;
    logic [BUS_W-1:0]  bus_s;
    logic [ADDR_W-1:0] addr_s;
    logic [7:0]        data_s;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        arr_rd;
    logic              busy;
    logic [7:0]        held_data;
    logic [7:0]        rd_word;

    assign ctl_raw = {~ce_n, ~oe_n, ~we_n, oe_hv};

    eep_sync #(.W(4)) u_sync_ctl (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    eep_sync #(.W(BUS_W)) u_sync_bus (
        .clk (clk),
        .rst (rst),
        .d   ({addr_i, data_i}),
        .q   (bus_s)
    );

    assign ctl    = ctrl_t'(ctl_s);
    assign addr_s = bus_s[BUS_W-1:BYTE_W];
    assign data_s = bus_s[BYTE_W-1:0];

    eep_seq #(
        .ADDR_W    (ADDR_W),
        .WRITE_CYC (WRITE_CYC),
        .CLEAR_CYC (CLEAR_CYC),
        .CLR_SETUP (CLR_SETUP)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .bus_addr  (addr_s),
        .bus_data  (data_s),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .held_data (held_data)
    );

    eep_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_addr (mem_addr),
        .wr_data (mem_wdata),
        .rd_addr (addr_s),
        .rd_data (arr_rd)
    );

    assign rd_word      = busy ? poll_word(held_data) : arr_rd;
    assign data_oe      = ctl.ce & ctl.oe;
    assign data_o       = data_oe ? rd_word : 8'h00;
    assign rdy_pull_low = busy;

    // R2: bus drive follows both strobes two clocks earlier
    a_r2_drive_gate: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (!$past(ce_n, 2) && !$past(oe_n, 2)));

    // R2: undriven bus reads as zero
    a_r2_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> (data_o == 8'h00));

    // R6: polling status carries only bit 7
    a_r6_poll_low_bits: assert property (@(posedge clk) disable iff (rst)
        (data_oe && rdy_pull_low) |-> (data_o[6:0] == 7'd0));

    // R5: array is only modified inside a busy period
    a_r5_write_in_busy: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> rdy_pull_low);
endmodule

// File: tb/eep_ctrl_tb.sv
module eep_ctrl_tb;
    localparam int AW    = 10;
    localparam int WCYC  = 40;
    localparam int CCYC  = 1500;
    localparam int SETUP = 4;
    localparam int TOP   = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    data_i = '0;
    logic [7:0]    data_o;
    logic          data_oe;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_hv = 1'b0;
    logic          rdy_pull_low;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    eep_ctrl #(
        .ADDR_W    (AW),
        .WRITE_CYC (WCYC),
        .CLEAR_CYC (CCYC),
        .CLR_SETUP (SETUP)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .addr_i       (addr_i),
        .data_i       (data_i),
        .data_o       (data_o),
        .data_oe      (data_oe),
        .ce_n         (ce_n),
        .oe_n         (oe_n),
        .we_n         (we_n),
        .oe_hv        (oe_hv),
        .rdy_pull_low (rdy_pull_low)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic read_byte(input logic [AW-1:0] a, output logic [7:0] v);
        addr_i = a;
        ce_n   = 1'b0;
        oe_n   = 1'b0;
        cyc(4);
        v = data_o;
        oe_n = 1'b1;
        ce_n = 1'b1;
        cyc(1);
    endtask

    task automatic write_byte(input logic [AW-1:0] a, input logic [7:0] d);
        addr_i = a;
        data_i = d;
        ce_n   = 1'b0;
        cyc(1);
        we_n = 1'b0;
        cyc(4);
        chk(rdy_pull_low == 1'b1, "R5 busy at write request", rdy_pull_low, 1);
        we_n = 1'b1;
        cyc(3);
        addr_i = ~a;
        data_i = ~d;
        ce_n   = 1'b1;
        cyc(1);
    endtask

    task automatic wait_ready(input int limit, output int n);
        n = 0;
        while (rdy_pull_low && n < limit) begin
            cyc(1);
            n++;
        end
    endtask

    task automatic t_reset;
        chk(rdy_pull_low == 1'b0, "R10 ready after reset", rdy_pull_low, 0);
        chk(data_oe == 1'b0, "R10 bus off after reset", data_oe, 0);
        chk(data_o == 8'h00, "R10 data zero after reset", data_o, 0);
    endtask

    task automatic t_standby;
        ce_n = 1'b1;
        oe_n = 1'b0;
        cyc(5);
        chk(data_oe == 1'b0, "R2 standby ignores oe_n", data_oe, 0);
        chk(data_o == 8'h00, "R2 standby data zero", data_o, 0);
        ce_n = 1'b0;
        oe_n = 1'b1;
        cyc(5);
        chk(data_oe == 1'b0, "R2 no drive without oe_n", data_oe, 0);
        ce_n = 1'b1;
        cyc(2);
    endtask

    task automatic t_write_poll(input logic [AW-1:0] a, input logic [7:0] d);
        logic [7:0] v;
        int n;
        write_byte(a, d);
        addr_i = a;
        ce_n   = 1'b0;
        oe_n   = 1'b0;
        cyc(4);
        chk(data_oe == 1'b1, "R2 drive while both low", data_oe, 1);
        chk(data_o == {~d[7], 7'b0}, "R6 poll value while busy", data_o, {~d[7], 7'b0});
        oe_n = 1'b1;
        ce_n = 1'b1;
        cyc(6);
        chk(rdy_pull_low == 1'b1, "R4 still busy mid cycle", rdy_pull_low, 1);
        wait_ready(WCYC + 40, n);
        chk(rdy_pull_low == 1'b0, "R4 ready after write cycle", rdy_pull_low, 0);
        read_byte(a, v);
        chk(v == d, "R1 R3 R6 true data after write", v, d);
    endtask

    task automatic t_ignore_busy;
        logic [7:0] v;
        int n;
        write_byte(10'h021, 8'h33);
        wait_ready(WCYC + 40, n);
        write_byte(10'h020, 8'h11);
        addr_i = 10'h021;
        data_i = 8'h77;
        ce_n   = 1'b0;
        cyc(1);
        we_n = 1'b0;
        cyc(4);
        we_n = 1'b1;
        cyc(3);
        ce_n = 1'b1;
        wait_ready(WCYC + 40, n);
        cyc(6);
        chk(rdy_pull_low == 1'b0, "R9 no cycle started after busy", rdy_pull_low, 0);
        read_byte(10'h021, v);
        chk(v == 8'h33, "R9 write during busy ignored", v, 8'h33);
        read_byte(10'h020, v);
        chk(v == 8'h11, "R1 first write intact", v, 8'h11);
    endtask

    task automatic t_clear_short;
        logic [7:0] v;
        int n;
        write_byte(10'h02C, 8'h5A);
        wait_ready(WCYC + 40, n);
        oe_hv = 1'b1;
        ce_n  = 1'b0;
        cyc(1);
        we_n = 1'b0;
        cyc(4);
        chk(rdy_pull_low == 1'b0, "R8 short setup clear ignored", rdy_pull_low, 0);
        we_n = 1'b1;
        cyc(3);
        oe_hv = 1'b0;
        cyc(2);
        ce_n = 1'b1;
        cyc(4);
        chk(rdy_pull_low == 1'b0, "R8 still ready", rdy_pull_low, 0);
        read_byte(10'h02C, v);
        chk(v == 8'h5A, "R8 data kept", v, 8'h5A);
    endtask

    task automatic t_clear;
        logic [7:0] v;
        int n;
        oe_hv = 1'b1;
        ce_n  = 1'b0;
        cyc(SETUP + 4);
        we_n = 1'b0;
        cyc(4);
        chk(rdy_pull_low == 1'b1, "R7 busy on clear pulse", rdy_pull_low, 1);
        we_n = 1'b1;
        cyc(1);
        oe_hv = 1'b0;
        oe_n  = 1'b0;
        cyc(6);
        chk(data_o == 8'h00, "R7 poll during clear", data_o, 0);
        oe_n = 1'b1;
        ce_n = 1'b1;
        cyc(CCYC / 2);
        chk(rdy_pull_low == 1'b1, "R7 busy mid clear", rdy_pull_low, 1);
        wait_ready(CCYC + 100, n);
        chk(rdy_pull_low == 1'b0, "R7 ready after clear", rdy_pull_low, 0);
        read_byte(10'h000, v);
        chk(v == 8'hFF, "R7 addr 0 erased", v, 8'hFF);
        read_byte(10'h02C, v);
        chk(v == 8'hFF, "R7 written byte erased", v, 8'hFF);
        read_byte(AW'(TOP), v);
        chk(v == 8'hFF, "R7 top addr erased", v, 8'hFF);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(3);
        t_reset();
        t_standby();
        t_write_poll(10'h155, 8'hA7);
        t_write_poll(10'h000, 8'h3C);
        t_write_poll(AW'(TOP), 8'hC3);
        t_ignore_busy();
        t_clear_short();
        t_clear();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule